// File: doc/BRIEF.md
# I2C slave clock-hold controller

This block is the target-side engine of a two-wire serial bus port. It synchronizes the SCL and SDA lines, finds start and stop conditions, shifts in the first byte after a start, and compares its upper seven bits with a programmable own address. It also recognizes the all-zero general-call address. Once addressed, it acknowledges bytes it receives, or it shifts out bytes that software writes when the bus master reads.

After every completed byte of an addressed transfer, the block raises a one-cycle interrupt. It drops its service flag and pulls SCL low, which stretches the clock until software services the data register. Any data-register read, any data-register write, or a software set of the flag ends the hold.

A master engine elsewhere in the port reports a lost arbitration. The block then treats itself as a target and signals the end of the current byte. Whether the flag drops at that point depends on where the loss happened.

Top module: `i2c_slave_hold`

## Requirements
- R1: After reset the service flag `svc_done` is 1, `scl_low` and `sda_low` are 0, `addressed` is 0 and no interrupt pulse occurs.
- R2: Address byte = {own 7-bit address, R/W} with `ack_en`=1 and `master_mode`=0: `sda_low` holds SDA low during the ninth clock. At the falling SCL edge that ends the ninth clock, `irq` pulses, `svc_done` goes to 0 and `scl_low` goes to 1.
- R3: Address byte 8'h00 (general call) is acknowledged and raises the interrupt like R2, sets `gen_call`, and always selects the receive direction (`xmit`=0).
- R4: Address byte not matching and not 8'h00: no acknowledge, no interrupt, `svc_done` stays 1, and later bytes up to the next stop or start are neither acknowledged nor interrupted.
- R5: With `ack_en`=0 a matching address is not acknowledged (SDA stays released) but is still addressed and still raises the interrupt.
- R6: In an addressed write (R/W=0), each further byte is received MSB first, appears on `dr_rdata`, is acknowledged only when `ack_en`=1, and raises the interrupt with the clock hold.
- R7: In an addressed read (R/W=1), `xmit`=1. A byte written via `dr_wr` is driven out MSB first, and `sda_low` changes only while SCL is low. Each byte, including its ninth clock, ends with the interrupt and the clock hold.
- R8: A pulse on `dr_rd`, `dr_wr` or `svc_set` sets `svc_done` to 1 and releases SCL. `svc_done` never rises otherwise.
- R9: If the end-of-byte raise and a release request fall in the same clock cycle, the raise wins: `svc_done` stays 0 and SCL stays held.
- R10: Arbitration lost (`arb_lost` pulse, with `master_mode` dropping to 0) during the address byte: `irq` pulses at the end of that byte. `svc_done` clears only if the address on the bus matches the own address; otherwise it stays 1.
- R11: Arbitration lost during a data byte: `irq` pulses at the end of that byte, `svc_done` stays 1 and SCL is not held.
- R12: A stop condition returns the block to idle and clears `addressed`, `gen_call` and `xmit`.
- R13: While `master_mode`=1, a matching address is neither acknowledged nor addressed and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| own_addr | input | DATA_W-1 | Programmed own target address |
| ack_en | input | 1 | Acknowledge enable |
| master_mode | input | 1 | The port's master engine owns the bus |
| arb_lost | input | 1 | One-cycle pulse: the master engine lost arbitration |
| dr_rd | input | 1 | Data-register read strobe |
| dr_wr | input | 1 | Data-register write strobe |
| dr_wdata | input | DATA_W | Byte to transmit |
| svc_set | input | 1 | Software write of 1 to the service flag |
| scl_low | output | 1 | Pull SCL low (open-drain) |
| sda_low | output | 1 | Pull SDA low (open-drain) |
| irq | output | 1 | One-cycle transfer-complete interrupt |
| svc_done | output | 1 | 1 = no service pending, 0 = hold active |
| addressed | output | 1 | Selected by own address or general call |
| gen_call | output | 1 | Current selection is a general call |
| xmit | output | 1 | Selected as transmitter |
| dr_rdata | output | DATA_W | Last byte received from the bus |

## Verification
Two things can land in one clock cycle: the end-of-byte raise of the hold and a software release by data-register access. The bench counts the synchronizer and edge-register stages from its own SCL fall. It places a `dr_rd` pulse on exactly the cycle in which the ninth-clock fall is acted on. It judges the result at the ports: the interrupt must still be counted, `svc_done` must read 0 and `scl_low` must stay 1 until a later, separate access releases it.

// File: rtl/i2c_slave_hold.sv
module i2c_slave_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              master_mode,
  input  logic              arb_lost,
  input  logic              dr_rd,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  input  logic              svc_set,
  output logic              scl_low,
  output logic              sda_low,
  output logic              irq,
  output logic              svc_done,
  output logic              addressed,
  output logic              gen_call,
  output logic              xmit,
  output logic [DATA_W-1:0] dr_rdata
);

  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ACKB = CW'(DATA_W);

  logic [2:0]        scl_s, sda_s;
  logic              active, addr_ph, armed, ack_out, lost_pend;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sr, tx_sr, rx_dat;

  wire scl_now  = scl_s[1];
  wire scl_prev = scl_s[2];
  wire sda_now  = sda_s[1];
  wire sda_prev = sda_s[2];
  wire scl_rise = scl_now & ~scl_prev;
  wire scl_fall = ~scl_now & scl_prev;
  wire start_c  = scl_now & scl_prev & sda_prev & ~sda_now;
  wire stop_c   = scl_now & scl_prev & ~sda_prev & sda_now;
  wire is_gc    = (sr == '0);
  wire hit      = ((sr[DATA_W-1:1] == own_addr) | is_gc) & ~master_mode;
  wire release_req = dr_rd | dr_wr | svc_set;

  assign scl_low  = ~svc_done;
  assign sda_low  = ack_out | (xmit & ~addr_ph & (cnt != ACKB) & ~tx_sr[DATA_W-1]);
  assign dr_rdata = rx_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s     <= 3'b111;
      sda_s     <= 3'b111;
      active    <= 1'b0;
      addr_ph   <= 1'b0;
      armed     <= 1'b0;
      ack_out   <= 1'b0;
      lost_pend <= 1'b0;
      addressed <= 1'b0;
      gen_call  <= 1'b0;
      xmit      <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      tx_sr     <= '1;
      rx_dat    <= '0;
      svc_done  <= 1'b1;
      irq       <= 1'b0;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      irq   <= 1'b0;
      if (arb_lost) lost_pend <= 1'b1;
      if (release_req) svc_done <= 1'b1;

      if (stop_c) begin
        active    <= 1'b0;
        addr_ph   <= 1'b0;
        armed     <= 1'b0;
        ack_out   <= 1'b0;
        lost_pend <= 1'b0;
        addressed <= 1'b0;
        gen_call  <= 1'b0;
        xmit      <= 1'b0;
        cnt       <= '0;
      end else if (start_c) begin
        active    <= 1'b1;
        addr_ph   <= 1'b1;
        armed     <= 1'b0;
        ack_out   <= 1'b0;
        addressed <= 1'b0;
        gen_call  <= 1'b0;
        xmit      <= 1'b0;
        cnt       <= '0;
        tx_sr     <= '1;
      end else if (active && scl_rise) begin
        armed <= 1'b1;
        if (cnt != ACKB) sr <= {sr[DATA_W-2:0], sda_now};
      end else if (active && scl_fall && armed) begin
        armed <= 1'b0;
        if (cnt == ACKB) begin
          cnt       <= '0;
          ack_out   <= 1'b0;
          addr_ph   <= 1'b0;
          lost_pend <= 1'b0;
          irq       <= addressed | lost_pend;
          if (addressed) svc_done <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          if (xmit && !addr_ph) tx_sr <= {tx_sr[DATA_W-2:0], 1'b1};
          if (cnt == LAST) begin
            rx_dat <= sr;
            if (addr_ph) begin
              addressed <= hit;
              gen_call  <= is_gc & ~master_mode;
              xmit      <= hit & sr[0];
              ack_out   <= hit & ack_en;
            end else begin
              ack_out <= addressed & ~xmit & ack_en;
            end
          end
        end
      end

      if (dr_wr) tx_sr <= dr_wdata;
    end
  end

  p_release_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_done) |-> $past(release_req));

  p_drop_with_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(svc_done) |-> irq);

  p_irq_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(scl_fall));

  p_sda_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !$past(scl_now));

  p_gc_receive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> !xmit);

  p_drive_needs_address_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> addressed);

endmodule

// File: tb/tb_i2c_slave_hold.sv
module tb_i2c_slave_hold;
  localparam int Q = 16;
  localparam logic [6:0] OWN = 7'h29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ack_en = 1'b1, master_mode = 1'b0, arb_lost = 1'b0;
  logic dr_rd = 1'b0, dr_wr = 1'b0, svc_set = 1'b0;
  logic [7:0] dr_wdata = '0;
  logic scl_low, sda_low, irq, svc_done, addressed, gen_call, xmit;
  logic [7:0] dr_rdata;
  wire scl_bus = scl_m & ~scl_low;
  wire sda_bus = sda_m & ~sda_low;

  int errs = 0, checks = 0, irqs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_slave_hold dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .own_addr(OWN),
    .ack_en(ack_en), .master_mode(master_mode), .arb_lost(arb_lost),
    .dr_rd(dr_rd), .dr_wr(dr_wr), .dr_wdata(dr_wdata), .svc_set(svc_set),
    .scl_low(scl_low), .sda_low(sda_low), .irq(irq), .svc_done(svc_done),
    .addressed(addressed), .gen_call(gen_call), .xmit(xmit), .dr_rdata(dr_rdata));

  always @(posedge clk) if (irq) irqs++;

  // {addr byte, ack_en, master_mode, exp ack level, exp irq, exp gc, exp xmit}
  localparam logic [13:0] VEC [7] = '{
    {8'h52, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h53, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h54, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h52, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h52, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, input bit coll, output logic s);
    sda_m = b;
    wq(Q);
    scl_m = 1'b1;
    wait_high();
    wq(Q);
    s = sda_bus;
    wq(Q);
    scl_m = 1'b0;
    if (coll) begin
      wq(2);
      dr_rd = 1'b1;
      wq(1);
      dr_rd = 1'b0;
      wq(Q - 3);
    end else begin
      wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int arb_at, input bit coll, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(b[i], 1'b0, s);
      if (8 - i == arb_at) begin
        arb_lost = 1'b1;
        master_mode = 1'b0;
        wq(1);
        arb_lost = 1'b0;
      end
    end
    clock_bit(1'b1, coll, ack);
  endtask

  task automatic recv_byte(input logic ackv, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clock_bit(ackv, 1'b0, s);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1;
    wq(Q);
    sda_m = 1'b0;
    wq(Q);
    scl_m = 1'b0;
    wq(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0;
    wq(Q);
    scl_m = 1'b1;
    wait_high();
    wq(Q);
    sda_m = 1'b1;
    wq(Q);
  endtask

  task automatic pulse_set();
    svc_set = 1'b1; wq(1); svc_set = 1'b0; wq(1);
  endtask

  task automatic pulse_rd();
    dr_rd = 1'b1; wq(1); dr_rd = 1'b0; wq(1);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    dr_wdata = d; dr_wr = 1'b1; wq(1); dr_wr = 1'b0; wq(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] got;
    int base;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    check("R1 svc_done", svc_done, 1);
    check("R1 scl_low", scl_low, 0);
    check("R1 sda_low", sda_low, 0);
    check("R1 addressed", addressed, 0);
    check("R1 irq count", irqs, 0);

    for (int v = 0; v < 7; v++) begin
      ack_en = VEC[v][5];
      master_mode = VEC[v][4];
      base = irqs;
      start_c();
      send_byte(VEC[v][13:6], 0, 1'b0, ack);
      check("R2/R3/R4/R5/R13 ack", ack, VEC[v][3]);
      check("R2/R3/R4/R5/R13 irq", irqs - base, VEC[v][2]);
      check("R2 svc_done", svc_done, !VEC[v][2]);
      check("R2 scl_low hold", scl_low, VEC[v][2]);
      check("R2/R4/R13 addressed", addressed, VEC[v][2]);
      check("R3 gen_call", gen_call, VEC[v][1]);
      check("R7 xmit", xmit, VEC[v][0]);
      if (VEC[v][2]) begin
        pulse_set();
        check("R8 set releases", {svc_done, scl_low}, 2'b10);
      end
      stop_c();
      check("R12 stop clears", {addressed, gen_call, xmit}, 3'b000);
      master_mode = 1'b0;
    end
    ack_en = 1'b1;

    // R6 receive path
    start_c();
    send_byte(8'h52, 0, 1'b0, ack);
    pulse_set();
    base = irqs;
    send_byte(8'hA5, 0, 1'b0, ack);
    check("R6 data ack", ack, 0);
    check("R6 rdata", dr_rdata, 8'hA5);
    check("R6 irq", irqs - base, 1);
    check("R6 hold", {svc_done, scl_low}, 2'b01);
    pulse_rd();
    check("R8 read releases", {svc_done, scl_low}, 2'b10);
    ack_en = 1'b0;
    send_byte(8'h3C, 0, 1'b0, ack);
    check("R6 no ack when disabled", ack, 1);
    check("R6 rdata 2", dr_rdata, 8'h3C);
    pulse_set();
    stop_c();
    ack_en = 1'b1;

    // R7 transmit path
    start_c();
    send_byte(8'h53, 0, 1'b0, ack);
    pulse_wr(8'hC6);
    check("R8 write releases", {svc_done, scl_low}, 2'b10);
    base = irqs;
    recv_byte(1'b0, got);
    check("R7 tx byte 1", got, 8'hC6);
    check("R7 irq", irqs - base, 1);
    check("R7 hold", svc_done, 0);
    pulse_wr(8'h5B);
    recv_byte(1'b1, got);
    check("R7 tx byte 2", got, 8'h5B);
    check("R7 irq 2", irqs - base, 2);
    pulse_set();
    check("R7 sda released after byte", sda_low, 0);
    stop_c();
    check("R12 stop clears xmit", {addressed, xmit}, 2'b00);

    // R9 collision of raise and release
    start_c();
    send_byte(8'h52, 0, 1'b0, ack);
    pulse_set();
    base = irqs;
    send_byte(8'h77, 0, 1'b1, ack);
    check("R9 irq counted", irqs - base, 1);
    check("R9 raise wins", {svc_done, scl_low}, 2'b01);
    pulse_rd();
    check("R9 later release", svc_done, 1);
    stop_c();

    // R4 unaddressed bytes ignored
    start_c();
    base = irqs;
    send_byte(8'h54, 0, 1'b0, ack);
    send_byte(8'h00, 0, 1'b0, ack);
    check("R4 data not acked", ack, 1);
    check("R4 no irq", irqs - base, 0);
    check("R4 no hold", {svc_done, scl_low}, 2'b10);
    stop_c();

    // R10 arbitration lost in address, matching
    master_mode = 1'b1;
    start_c();
    base = irqs;
    send_byte(8'h52, 3, 1'b0, ack);
    check("R10 match ack", ack, 0);
    check("R10 match irq", irqs - base, 1);
    check("R10 match flag clears", {svc_done, scl_low}, 2'b01);
    pulse_set();
    stop_c();

    // R10 arbitration lost in address, not matching
    master_mode = 1'b1;
    start_c();
    base = irqs;
    send_byte(8'h60, 3, 1'b0, ack);
    check("R10 nomatch ack", ack, 1);
    check("R10 nomatch irq", irqs - base, 1);
    check("R10 nomatch flag stays", {svc_done, scl_low}, 2'b10);
    stop_c();

    // R11 arbitration lost in data
    master_mode = 1'b1;
    start_c();
    send_byte(8'h60, 0, 1'b0, ack);
    base = irqs;
    send_byte(8'h0F, 2, 1'b0, ack);
    check("R11 irq", irqs - base, 1);
    check("R11 flag stays", {svc_done, scl_low}, 2'b10);
    stop_c();
    check("R12 idle after stop", addressed, 0);

    finish_run();
  end
endmodule